// File: doc/BRIEF.md
# Memory-Mapped Console Controller

This block is a console device on a processor's word-addressed memory bus. It presents four word registers in a 16-byte window at the top of the address space: receive control, receive data, transmit control and transmit data. A byte arriving on a valid/data input stream is held in the block and flagged as ready. Software either polls that flag or takes an interrupt, then reads the byte. For output, software waits until the transmitter is ready and then writes a byte. The block offers that byte on a valid/ready output stream until a consumer accepts it.

Each side has its own interrupt enable. An interrupt line is raised while its side is ready and enabled. The bus is a single-cycle strobe. Read data is combinational from the address. Read and write side effects take place on the clock edge that ends the access.

Top module: `mmio_console`

## Requirements
- R1: After reset, receive ready is 0 and transmit ready is 1. Both interrupt enables and the overrun flag are 0, and the output stream is idle. The receive control register reads 0 and the transmit control register reads 1.
- R2: A cycle with `rx_in_valid` high latches `rx_in_data` and sets receive ready. Receive ready is bit 0 of the receive control register at address 0xFFFF0000.
- R3: A read of the receive data register at 0xFFFF0004 returns the latched byte zero-extended to 32 bits. That read clears receive ready.
- R4: A byte that arrives while receive ready is 1, in a cycle with no data read, replaces the held byte and sets the overrun flag at bit 2 of receive control. A receive data read clears the overrun flag.
- R5: A write to either control register changes only the interrupt enable at bit 1. The ready and overrun bits ignore the written value.
- R6: A write to the transmit data register at 0xFFFF000C while transmit ready is 1 takes bits 7:0 of the write data. It clears transmit ready (bit 0 of transmit control at 0xFFFF0008) and presents the byte with `tx_out_valid` high on the following cycle.
- R7: Once `tx_out_valid` and `tx_out_ready` are both high on a clock edge, transmit ready returns to 1 and `tx_out_valid` drops.
- R8: A write to the transmit data register while transmit ready is 0 is dropped. The pending byte is neither altered nor sent twice.
- R9: `irq_rx` equals receive ready AND receive interrupt enable. `irq_tx` equals transmit ready AND transmit interrupt enable.
- R10: An access that is not word aligned, or that falls outside the four-register window, reads as 0 and changes no state. Transmit data reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| rx_in_valid | input | 1 | Received byte present |
| rx_in_data | input | 8 | Received byte |
| tx_out_valid | output | 1 | Output byte pending |
| tx_out_ready | input | 1 | Consumer accepts the output byte |
| tx_out_data | output | 8 | Output byte |
| irq_rx | output | 1 | Receive interrupt request |
| irq_tx | output | 1 | Transmit interrupt request |

## Verification
Several properties are checked on every cycle. Receive ready rises after any arriving byte and falls after a data read with no arrival. Overrun sets when a byte lands on a held byte. A transmit write issued while ready produces the written byte on the stream, a handshake restores ready, and a write while busy leaves the pending byte untouched. An access outside the window reads zero. The bench scenarios are the only place that shows the register read values, the zero extension, that control writes leave the ready bits alone, the interrupt gating, and that dropped transmit writes never reach the stream. They also show the order and count of the output bytes, which the scoreboard tracks.

// File: rtl/mmio_console_pkg.sv
package mmio_console_pkg;

   localparam int unsigned NUM_REGS = 4;
   localparam int unsigned IDX_W    = 2;

   typedef enum logic [IDX_W-1:0] {
      REG_RX_CTL = 2'd0,
      REG_RX_DAT = 2'd1,
      REG_TX_CTL = 2'd2,
      REG_TX_DAT = 2'd3
   } reg_idx_e;

   localparam int unsigned BIT_RDY = 0;
   localparam int unsigned BIT_IE  = 1;
   localparam int unsigned BIT_OVR = 2;

endpackage

// File: rtl/mmio_console_decode.sv
module mmio_console_decode
   import mmio_console_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 32,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
   input  logic                bus_sel,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   output logic                hit,
   output logic [IDX_W-1:0]    idx,
   output logic [NUM_REGS-1:0] rd_stb,
   output logic [NUM_REGS-1:0] wr_stb
);
   localparam int unsigned LOW_W = IDX_W + 2;

   if (ADDR_W <= LOW_W) begin : g_bad_addr_w
      $error("ADDR_W too small for the register window");
   end

   assign hit = bus_sel
             && (bus_addr[ADDR_W-1:LOW_W] == BASE_ADDR[ADDR_W-1:LOW_W])
             && (bus_addr[1:0] == 2'b00);
   assign idx = bus_addr[LOW_W-1:2];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_stb
      assign rd_stb[i] = hit && !bus_wr && (idx == IDX_W'(i));
      assign wr_stb[i] = hit &&  bus_wr && (idx == IDX_W'(i));
   end

   logic unused_base;
   assign unused_base = ^BASE_ADDR[LOW_W-1:0];

endmodule

// File: rtl/mmio_console_rx.sv
module mmio_console_rx #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_data,
   input  logic              ctl_wr,
   input  logic              ie_wdata,
   input  logic              data_rd,
   output logic              rdy,
   output logic              ie,
   output logic              ovr,
   output logic [BYTE_W-1:0] byte_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdy    <= 1'b0;
         ie     <= 1'b0;
         ovr    <= 1'b0;
         byte_q <= '0;
      end else begin
         if (ctl_wr) ie <= ie_wdata;
         if (in_valid) begin
            byte_q <= in_data;
            rdy    <= 1'b1;
         end else if (data_rd) begin
            rdy    <= 1'b0;
         end
         if (in_valid && rdy && !data_rd) ovr <= 1'b1;
         else if (data_rd)                ovr <= 1'b0;
      end
   end

   // R2
   rx_ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> rdy && (byte_q == $past(in_data)));

   // R3
   rx_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_rd && !in_valid |=> !rdy);

   // R4
   rx_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && rdy && !data_rd |=> ovr);

endmodule

// File: rtl/mmio_console_tx.sv
module mmio_console_tx #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic              ie_wdata,
   input  logic              data_wr,
   input  logic [BYTE_W-1:0] wdata_byte,
   input  logic              out_ready,
   output logic              rdy,
   output logic              ie,
   output logic              out_valid,
   output logic [BYTE_W-1:0] out_data
);
   logic busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         ie       <= 1'b0;
         out_data <= '0;
      end else begin
         if (ctl_wr) ie <= ie_wdata;
         if (data_wr && !busy) begin
            busy     <= 1'b1;
            out_data <= wdata_byte;
         end else if (busy && out_ready) begin
            busy     <= 1'b0;
         end
      end
   end

   assign rdy       = !busy;
   assign out_valid = busy;

   // R6
   tx_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_wr && rdy |=> out_valid && !rdy && (out_data == $past(wdata_byte)));

   // R7
   tx_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready |=> rdy);

   // R8
   tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_wr && !rdy && !out_ready |=> out_valid && $stable(out_data));

endmodule

// File: rtl/mmio_console.sv
module mmio_console
   import mmio_console_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 32,
   parameter int unsigned       DATA_W    = 32,
   parameter int unsigned       BYTE_W    = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              rx_in_valid,
   input  logic [BYTE_W-1:0] rx_in_data,
   output logic              tx_out_valid,
   input  logic              tx_out_ready,
   output logic [BYTE_W-1:0] tx_out_data,
   output logic              irq_rx,
   output logic              irq_tx
);
   localparam int unsigned PAD_W = DATA_W - BYTE_W;

   if (DATA_W < BYTE_W || DATA_W <= BIT_OVR) begin : g_bad_data_w
      $error("DATA_W must hold a byte and the status bits");
   end
   if (BASE_ADDR[3:0] != 4'h0) begin : g_bad_base
      $error("BASE_ADDR must be 16-byte aligned");
   end

   logic                hit;
   logic [IDX_W-1:0]    idx;
   logic [NUM_REGS-1:0] rd_stb;
   logic [NUM_REGS-1:0] wr_stb;
   logic                rx_rdy, rx_ie, rx_ovr;
   logic [BYTE_W-1:0]   rx_byte;
   logic                tx_rdy, tx_ie;

   mmio_console_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
      .bus_sel (bus_sel),
      .bus_wr  (bus_wr),
      .bus_addr(bus_addr),
      .hit     (hit),
      .idx     (idx),
      .rd_stb  (rd_stb),
      .wr_stb  (wr_stb)
   );

   mmio_console_rx #(.BYTE_W(BYTE_W)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_valid(rx_in_valid),
      .in_data (rx_in_data),
      .ctl_wr  (wr_stb[REG_RX_CTL]),
      .ie_wdata(bus_wdata[BIT_IE]),
      .data_rd (rd_stb[REG_RX_DAT]),
      .rdy     (rx_rdy),
      .ie      (rx_ie),
      .ovr     (rx_ovr),
      .byte_q  (rx_byte)
   );

   mmio_console_tx #(.BYTE_W(BYTE_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_wr    (wr_stb[REG_TX_CTL]),
      .ie_wdata  (bus_wdata[BIT_IE]),
      .data_wr   (wr_stb[REG_TX_DAT]),
      .wdata_byte(bus_wdata[BYTE_W-1:0]),
      .out_ready (tx_out_ready),
      .rdy       (tx_rdy),
      .ie        (tx_ie),
      .out_valid (tx_out_valid),
      .out_data  (tx_out_data)
   );

   always_comb begin
      bus_rdata = '0;
      if (hit && !bus_wr) begin
         unique case (reg_idx_e'(idx))
            REG_RX_CTL: begin
               bus_rdata[BIT_RDY] = rx_rdy;
               bus_rdata[BIT_IE]  = rx_ie;
               bus_rdata[BIT_OVR] = rx_ovr;
            end
            REG_RX_DAT: bus_rdata = {{PAD_W{1'b0}}, rx_byte};
            REG_TX_CTL: begin
               bus_rdata[BIT_RDY] = tx_rdy;
               bus_rdata[BIT_IE]  = tx_ie;
            end
            default:    bus_rdata = '0;
         endcase
      end
   end

   assign irq_rx = rx_rdy & rx_ie;
   assign irq_tx = tx_rdy & tx_ie;

   logic unused_wdata;
   assign unused_wdata = ^bus_wdata;

   // R10
   miss_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_sel && !hit |-> bus_rdata == '0);

   // R9
   irq_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_rx |-> rx_rdy) and (irq_tx |-> tx_rdy));

endmodule

// File: tb/mmio_console_tb.sv
module mmio_console_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [31:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
   logic        rx_in_valid = 1'b0;
   logic [7:0]  rx_in_data = '0;
   logic        tx_out_valid, tx_out_ready = 1'b0;
   logic [7:0]  tx_out_data;
   logic        irq_rx, irq_tx;

   int n_run = 0, n_fail = 0;
   logic [7:0] exp_q[$];

   localparam logic [31:0] A_RXC = 32'hFFFF_0000;
   localparam logic [31:0] A_RXD = 32'hFFFF_0004;
   localparam logic [31:0] A_TXC = 32'hFFFF_0008;
   localparam logic [31:0] A_TXD = 32'hFFFF_000C;

   always #4 clk = ~clk;

   mmio_console u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data),
      .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
      .tx_out_data(tx_out_data), .irq_rx(irq_rx), .irq_tx(irq_tx)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(logic [31:0] a, logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(logic [31:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic rx_push(logic [7:0] b);
      @(negedge clk);
      rx_in_valid = 1'b1; rx_in_data = b;
      @(negedge clk);
      rx_in_valid = 1'b0;
   endtask

   task automatic tx_send(logic [7:0] b, bit expect_taken);
      if (expect_taken) exp_q.push_back(b);
      bus_write(A_TXD, {24'hABCDEF, b});
   endtask

   // scoreboard monitor: sample between edges
   always @(negedge clk) begin
      #2;
      if (rst_n && tx_out_valid && tx_out_ready) begin
         if (exp_q.size() == 0) begin
            n_run++; n_fail++;
            $display("FAIL R8: actual byte %h expected none", tx_out_data);
         end else begin
            check("R6/R7 stream byte", {24'h0, tx_out_data}, {24'h0, exp_q.pop_front()});
         end
      end
   end

   initial begin
      #1_000_000;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      bus_read(A_RXC, d); check("R1 rx ctl", d, 32'h0);
      bus_read(A_TXC, d); check("R1 tx ctl", d, 32'h1);
      check("R1 irqs/out_valid", {29'h0, irq_rx, irq_tx, tx_out_valid}, 32'h0);

      // R2, R3
      rx_push(8'h3C);
      bus_read(A_RXC, d); check("R2 rx ready", d, 32'h1);
      bus_read(A_RXD, d); check("R3 rx data", d, 32'h3C);
      bus_read(A_RXC, d); check("R3 ready cleared", d, 32'h0);
      rx_push(8'hF0);
      bus_read(A_RXD, d); check("R3 zero extend", d, 32'h0000_00F0);

      // R4 overrun
      rx_push(8'h11); rx_push(8'h22);
      bus_read(A_RXC, d); check("R4 overrun set", d, 32'h5);
      bus_read(A_RXD, d); check("R4 newest byte", d, 32'h22);
      bus_read(A_RXC, d); check("R4 overrun cleared", d, 32'h0);

      // R5, R9 rx side
      bus_write(A_RXC, 32'hFFFF_FFFF);
      bus_read(A_RXC, d); check("R5 only ie set", d, 32'h2);
      check("R9 irq_rx idle", {31'h0, irq_rx}, 32'h0);
      rx_push(8'h55);
      check("R9 irq_rx raised", {31'h0, irq_rx}, 32'h1);
      bus_write(A_RXC, 32'h0000_0005);
      check("R9 irq_rx masked", {31'h0, irq_rx}, 32'h0);
      bus_read(A_RXC, d); check("R5 ready kept", d, 32'h1);
      bus_read(A_RXD, d); check("R3 data 55", d, 32'h55);

      // R10 misses
      rx_push(8'h66);
      bus_read(32'hFFFF_0005, d); check("R10 misaligned read", d, 32'h0);
      bus_read(32'h7FFF_0004, d); check("R10 outside read", d, 32'h0);
      bus_write(32'hFFFF_0010, 32'h2);
      bus_write(32'hFFFF_0001, 32'h2);
      bus_read(A_RXC, d); check("R10 no side effect", d, 32'h1);
      bus_read(A_RXD, d); check("R10 byte intact", d, 32'h66);
      bus_read(A_TXD, d); check("R10 tx data reads 0", d, 32'h0);

      // R6..R9 tx side
      bus_write(A_TXC, 32'hFFFF_FFFE);
      bus_read(A_TXC, d); check("R5 tx ctl", d, 32'h3);
      check("R9 irq_tx raised", {31'h0, irq_tx}, 32'h1);
      tx_send(8'hA5, 1'b1);
      bus_read(A_TXC, d); check("R6 tx busy", d, 32'h2);
      check("R6 out", {23'h0, tx_out_valid, tx_out_data}, {23'h0, 1'b1, 8'hA5});
      check("R9 irq_tx low", {31'h0, irq_tx}, 32'h0);
      tx_send(8'h77, 1'b0);
      check("R8 byte held", {23'h0, tx_out_valid, tx_out_data}, {23'h0, 1'b1, 8'hA5});
      @(negedge clk); tx_out_ready = 1'b1;
      repeat (2) @(negedge clk);
      bus_read(A_TXC, d); check("R7 ready back", d, 32'h3);
      check("R7 out idle", {31'h0, tx_out_valid}, 32'h0);
      tx_send(8'h5A, 1'b1);
      repeat (3) @(negedge clk);
      tx_send(8'hC3, 1'b1);
      repeat (3) @(negedge clk);
      check("R7 scoreboard drained", exp_q.size(), 32'h0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule